// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the 256-byte type-0 configuration header and device-specific register space of a host bridge function. A configuration agent elsewhere in the chip has already decoded the bus cycle. It reaches the storage through a byte-wide port that carries a function number, an 8-bit offset, write data and a write strobe. Read data comes back combinationally from storage in the same cycle. A write lands on the next rising clock edge.

Each offset follows one of three access policies:
- Identity bytes are hard read-only. The vendor and device codes come from module parameters.
- The upper status byte has three sticky error flags that software can only clear, by writing ones.
- Every other byte is plain read/write.

Function numbers other than zero are not implemented. Reads to them see all ones, and writes to them are dropped. The three memory-shadow control bytes are driven out continuously to a downstream attribute decoder. A soft-reset pulse returns the top BIOS segment's routing field to external (bits 5:4 of the third shadow byte) and leaves all other state alone. The synchronous hard reset loads the documented power-on defaults.

Top module: `hbcfg_space`

## Requirements
- R1: After hard reset (rst_n low at a clock edge), every byte holds its default. The defaults are: 0x04=0x07, 0x06=0xA0, 0x07=0x02, 0x0B=0x06, 0x58=0x40, 0x59=0x05, 0x5A through 0x5F=0x01, 0x64=0xAB. All other bytes are 0x00, except the identity bytes of R2.
- R2: Offsets 0x00/0x01 read as the low/high bytes of parameter VENDOR_ID. Offsets 0x02/0x03 read as the low/high bytes of parameter DEVICE_ID.
- R3: Writes to offsets 0x00–0x03, 0x08–0x0B, 0x0E and 0x0F leave those bytes unchanged.
- R4: At offset 0x07, a write clears each of bits 7, 5 and 4 that is written as 1. No write ever sets any bit of this byte, and bits 6 and 3:0 never change through writes.
- R5: At every other offset, a function-0 write stores the written byte. The new value is visible from the clock edge that takes the write.
- R6: A read with cfg_func other than 0 returns 0xFF. A read with cfg_func equal to 0 returns the stored byte at cfg_addr in the same cycle.
- R7: A write with cfg_func other than 0 changes no byte.
- R8: A clock edge with soft_rst high does three things. It clears bits 5:4 of offset 0x63 and keeps that byte's other bits. It discards a write to 0x63 issued in the same cycle. It leaves every other byte as it was, and writes to those bytes still take effect.
- R9: Outputs shadow_lo, shadow_mid and shadow_hi always equal the bytes at offsets 0x61, 0x62 and 0x63.
- R10: A write alters only the byte at its own offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| soft_rst | input | 1 | Soft-reset pulse, clears the top-segment routing field |
| cfg_func | input | 3 | Function number of the access |
| cfg_addr | input | 8 | Byte offset in configuration space |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write strobe |
| cfg_rdata | output | 8 | Combinational read data |
| shadow_lo | output | 8 | Shadow control byte at 0x61 |
| shadow_mid | output | 8 | Shadow control byte at 0x62 |
| shadow_hi | output | 8 | Shadow control byte at 0x63 |

## Verification
The bench first attacks the read-only identity bytes and the status byte with all-ones and mixed patterns. A design that treated either as plain storage would read back the written value instead of the identity code or 0x02. It writes to functions 1 and 7 on offsets that hold known data, which catches a decoder that ignores the function number. It then fires soft reset on its own and together with a write to 0x63, which exposes a design that clears the wrong field, loses the preserved bits, or lets the coincident write through. It also sweeps all 256 defaults after reset and probes neighbouring offsets, so a mis-indexed reset table or a write that spills into the next byte shows up directly.

// File: rtl/hbcfg_pkg.sv
// Package: shared access-policy type and per-offset constants for the
// host bridge configuration space. Assumes 8-bit offsets and byte data.
package hbcfg_pkg;

    typedef enum logic [1:0] {
        ACC_RW  = 2'd0,
        ACC_RO  = 2'd1,
        ACC_W1C = 2'd2
    } acc_e;

    localparam logic [7:0] OFF_STATUS_HI = 8'h07;
    localparam logic [7:0] OFF_SHADOW_LO = 8'h61;
    localparam logic [7:0] OFF_SHADOW_MD = 8'h62;
    localparam logic [7:0] OFF_SHADOW_HI = 8'h63;
    localparam logic [7:0] STATUS_W1C_MASK = 8'hB0;
    localparam logic [7:0] SHADOW_SOFT_MASK = 8'h30;

    // Access policy of one offset.
    function automatic acc_e acc_class(input int unsigned off);
        acc_e c;
        case (off)
            32'h00, 32'h01, 32'h02, 32'h03,
            32'h08, 32'h09, 32'h0A, 32'h0B,
            32'h0E, 32'h0F:      c = ACC_RO;
            32'h07:              c = ACC_W1C;
            default:             c = ACC_RW;
        endcase
        return c;
    endfunction

    // Hard-reset value of one offset.
    function automatic logic [7:0] rst_value(input int unsigned off,
                                             input logic [15:0] vid,
                                             input logic [15:0] did);
        logic [7:0] v;
        case (off)
            32'h00:  v = vid[7:0];
            32'h01:  v = vid[15:8];
            32'h02:  v = did[7:0];
            32'h03:  v = did[15:8];
            32'h04:  v = 8'h07;
            32'h06:  v = 8'hA0;
            32'h07:  v = 8'h02;
            32'h0B:  v = 8'h06;
            32'h58:  v = 8'h40;
            32'h59:  v = 8'h05;
            32'h5A, 32'h5B, 32'h5C,
            32'h5D, 32'h5E, 32'h5F: v = 8'h01;
            32'h64:  v = 8'hAB;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    // Soft-reset clear mask of one offset.
    function automatic logic [7:0] soft_mask(input int unsigned off);
        return (off == 32'(OFF_SHADOW_HI)) ? SHADOW_SOFT_MASK : 8'h00;
    endfunction

endpackage

// File: rtl/hbcfg_wrdec.sv
// Module: hbcfg_wrdec
// Turns the port write strobe into a one-hot select per offset. Only
// function 0 is implemented, so writes to any other function select
// nothing. Assumes NUM_REGS equals 2**ADDR_W.
module hbcfg_wrdec #(
    parameter int ADDR_W = 8,
    parameter int FUNC_W = 3,
    localparam int NUM_REGS = 1 << ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [FUNC_W-1:0]   func,
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] wr_sel
);

    // Decode the addressed offset for function 0 only.
    always_comb begin
        wr_sel = '0;
        if (we && (func == '0)) begin
            wr_sel[addr] = 1'b1;
        end
    end

    AST_WSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel)); // R10
    AST_FOREIGN_FUNC_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
        (func != '0) |-> (wr_sel == '0)); // R7

endmodule

// File: rtl/hbcfg_cell.sv
// Module: hbcfg_cell
// One configuration byte with an access policy fixed at elaboration:
// plain read/write, read-only, or write-1-to-clear within W1C_MASK
// (bits outside the mask are read-only). A soft-reset pulse clears
// SOFT_MASK bits and takes priority over a coincident write; cells with
// a zero SOFT_MASK ignore the pulse.
module hbcfg_cell #(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] RST_VAL = '0,
    parameter hbcfg_pkg::acc_e ACC = hbcfg_pkg::ACC_RW,
    parameter logic [DATA_W-1:0] W1C_MASK = '0,
    parameter logic [DATA_W-1:0] SOFT_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    import hbcfg_pkg::*;

    localparam bit HAS_SOFT = (SOFT_MASK != '0);

    // Byte storage update under the cell's access policy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (HAS_SOFT && soft_clr) begin
            q <= q & ~SOFT_MASK;
        end else if (wr_en) begin
            case (ACC)
                ACC_RW:  q <= wdata;
                ACC_W1C: q <= q & ~(wdata & W1C_MASK);
                default: q <= q;
            endcase
        end
    end

    generate
        if (ACC == ACC_RO) begin : g_ro_chk
            AST_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> $stable(q)); // R3
        end
        if (ACC == ACC_W1C) begin : g_w1c_chk
            AST_W1C_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> ((q & ~$past(q)) == '0)); // R4
        end
        if (HAS_SOFT) begin : g_soft_chk
            AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                soft_clr |=> ((q & SOFT_MASK) == '0)); // R8
            AST_SOFT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                soft_clr |=> ((q & ~SOFT_MASK) == ($past(q) & ~SOFT_MASK))); // R8
        end
    endgenerate

endmodule

// File: rtl/hbcfg_rdmux.sv
// Module: hbcfg_rdmux
// Combinational read path: selects the addressed byte from the flattened
// storage for function 0 and returns all ones for any other function.
module hbcfg_rdmux #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int FUNC_W = 3,
    localparam int NUM_REGS = 1 << ADDR_W
) (
    input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
    input  logic [FUNC_W-1:0]          func,
    input  logic [ADDR_W-1:0]          addr,
    output logic [DATA_W-1:0]          rdata
);

    // Pick the stored byte or the absent-function pattern.
    always_comb begin
        if (func == '0) begin
            rdata = regs_flat[addr*DATA_W +: DATA_W];
        end else begin
            rdata = '1;
        end
    end

endmodule

// File: rtl/hbcfg_space.sv
// Module: hbcfg_space
// Host bridge configuration space: 2**ADDR_W bytes, each a policy cell,
// a write decoder, a read mux, and continuous export of the three shadow
// control bytes. Assumes the caller has decoded the configuration cycle
// and presents one byte access per clock.
module hbcfg_space #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int FUNC_W = 3,
    parameter logic [15:0] VENDOR_ID = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID = 16'h3C4D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [FUNC_W-1:0] cfg_func,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              cfg_we,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [DATA_W-1:0] shadow_lo,
    output logic [DATA_W-1:0] shadow_mid,
    output logic [DATA_W-1:0] shadow_hi
);
    import hbcfg_pkg::*;

    localparam int NUM_REGS = 1 << ADDR_W;

    logic [NUM_REGS-1:0]        wr_sel;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;

    hbcfg_wrdec #(.ADDR_W(ADDR_W), .FUNC_W(FUNC_W)) u_wrdec (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .func   (cfg_func),
        .addr   (cfg_addr),
        .wr_sel (wr_sel)
    );

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
            localparam acc_e CLS = acc_class(i);
            hbcfg_cell #(
                .DATA_W    (DATA_W),
                .RST_VAL   (DATA_W'(rst_value(i, VENDOR_ID, DEVICE_ID))),
                .ACC       (CLS),
                .W1C_MASK  ((CLS == ACC_W1C) ? DATA_W'(STATUS_W1C_MASK) : '0),
                .SOFT_MASK (DATA_W'(soft_mask(i)))
            ) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .soft_clr (soft_rst),
                .wr_en    (wr_sel[i]),
                .wdata    (cfg_wdata),
                .q        (regs_flat[i*DATA_W +: DATA_W])
            );
        end
    endgenerate

    hbcfg_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FUNC_W(FUNC_W)) u_rdmux (
        .regs_flat (regs_flat),
        .func      (cfg_func),
        .addr      (cfg_addr),
        .rdata     (cfg_rdata)
    );

    // Continuous export of the shadow control bytes.
    always_comb begin
        shadow_lo  = regs_flat[int'(OFF_SHADOW_LO)*DATA_W +: DATA_W];
        shadow_mid = regs_flat[int'(OFF_SHADOW_MD)*DATA_W +: DATA_W];
        shadow_hi  = regs_flat[int'(OFF_SHADOW_HI)*DATA_W +: DATA_W];
    end

    AST_OTHER_FUNC_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_func != '0) |-> (cfg_rdata == '1)); // R6
    AST_SHADOW_LO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_func == '0 && cfg_addr == ADDR_W'(OFF_SHADOW_LO))
        |=> (shadow_lo == $past(cfg_wdata))); // R9
    AST_SHADOW_HI_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ((shadow_hi & DATA_W'(SHADOW_SOFT_MASK)) == '0)); // R8

endmodule

// File: tb/hbcfg_space_test.sv
`timescale 1ns/1ps
// Bench for hbcfg_space: a vector table walked by one loop, then directed
// checks of reset defaults, foreign-function reads, shadow export and
// soft reset.
module hbcfg_space_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic [2:0] cfg_func = '0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_rdata, shadow_lo, shadow_mid, shadow_hi;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hbcfg_space #(.VENDOR_ID(16'h1A2B), .DEVICE_ID(16'h3C4D)) uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg_func(cfg_func), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
        .shadow_lo(shadow_lo), .shadow_mid(shadow_mid), .shadow_hi(shadow_hi)
    );

    // Vector: {func, write addr, write data, read addr, expected, req}
    localparam int NV = 17;
    localparam logic [42:0] VEC [NV] = '{
        {3'd0, 8'h00, 8'hFF, 8'h00, 8'h2B, 8'd3},  // R3 vendor low
        {3'd0, 8'h03, 8'h00, 8'h03, 8'h3C, 8'd3},  // R3 device high
        {3'd0, 8'h0B, 8'h00, 8'h0B, 8'h06, 8'd3},  // R3 class code
        {3'd0, 8'h0E, 8'h5A, 8'h0E, 8'h00, 8'd3},  // R3
        {3'd0, 8'h09, 8'h77, 8'h09, 8'h00, 8'd3},  // R3
        {3'd0, 8'h07, 8'hFF, 8'h07, 8'h02, 8'd4},  // R4 all ones
        {3'd0, 8'h07, 8'h4D, 8'h07, 8'h02, 8'd4},  // R4 no set of bit 6/3:0
        {3'd0, 8'h61, 8'hA5, 8'h61, 8'hA5, 8'd5},  // R5
        {3'd0, 8'h62, 8'h3C, 8'h62, 8'h3C, 8'd5},  // R5
        {3'd0, 8'h63, 8'hF3, 8'h63, 8'hF3, 8'd5},  // R5
        {3'd0, 8'h64, 8'h12, 8'h64, 8'h12, 8'd5},  // R5
        {3'd0, 8'h04, 8'h00, 8'h04, 8'h00, 8'd5},  // R5 command
        {3'd0, 8'hFF, 8'h81, 8'hFF, 8'h81, 8'd5},  // R5 top offset
        {3'd1, 8'h40, 8'h99, 8'h40, 8'h00, 8'd7},  // R7
        {3'd7, 8'h61, 8'h00, 8'h61, 8'hA5, 8'd7},  // R7
        {3'd0, 8'h10, 8'h11, 8'h11, 8'h00, 8'd10}, // R10 neighbour above
        {3'd0, 8'h10, 8'h22, 8'h0F, 8'h00, 8'd10}  // R10 neighbour below
    };

    // Expected hard-reset value of an offset, from R1 and R2.
    function automatic logic [7:0] exp_default(input int off);
        if (off == 0) return 8'h2B;
        if (off == 1) return 8'h1A;
        if (off == 2) return 8'h4D;
        if (off == 3) return 8'h3C;
        if (off == 4) return 8'h07;
        if (off == 6) return 8'hA0;
        if (off == 7) return 8'h02;
        if (off == 11) return 8'h06;
        if (off == 8'h58) return 8'h40;
        if (off == 8'h59) return 8'h05;
        if (off >= 8'h5A && off <= 8'h5F) return 8'h01;
        if (off == 8'h64) return 8'hAB;
        return 8'h00;
    endfunction

    task automatic check(input logic [7:0] got, input logic [7:0] exp,
                         input int req, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] f, input logic [7:0] a,
                            input logic [7:0] d);
        @(negedge clk);
        cfg_func = f; cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] f, input logic [7:0] a,
                           output logic [7:0] d);
        cfg_func = f; cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic hard_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [7:0] rd;
        hard_reset();

        // R1 and R2: full sweep of defaults
        for (int i = 0; i < 256; i++) begin
            do_read(3'd0, 8'(i), rd);
            check(rd, exp_default(i), (i < 4) ? 2 : 1, $sformatf("default at %02h", i));
        end

        // Vector table
        for (int v = 0; v < NV; v++) begin
            do_write(VEC[v][42:40], VEC[v][39:32], VEC[v][31:24]);
            do_read(3'd0, VEC[v][23:16], rd);
            check(rd, VEC[v][15:8], int'(VEC[v][7:0]), $sformatf("vector %0d", v));
        end

        // R6: other functions read all ones, function 0 reads storage
        do_read(3'd1, 8'h00, rd);  check(rd, 8'hFF, 6, "func1 id read");
        do_read(3'd5, 8'h61, rd);  check(rd, 8'hFF, 6, "func5 shadow read");
        do_read(3'd7, 8'h0E, rd);  check(rd, 8'hFF, 6, "func7 zero byte");
        do_read(3'd0, 8'h64, rd);  check(rd, 8'h12, 6, "func0 read");

        // R9: shadow outputs mirror stored bytes
        #1;
        check(shadow_lo, 8'hA5, 9, "shadow_lo");
        check(shadow_mid, 8'h3C, 9, "shadow_mid");
        check(shadow_hi, 8'hF3, 9, "shadow_hi");

        // R8: soft reset alone
        @(negedge clk); soft_rst = 1'b1;
        @(posedge clk); @(negedge clk); soft_rst = 1'b0;
        do_read(3'd0, 8'h63, rd);  check(rd, 8'hC3, 8, "soft clear 0x63");
        check(shadow_hi, 8'hC3, 8, "soft clear shadow_hi");
        do_read(3'd0, 8'h61, rd);  check(rd, 8'hA5, 8, "soft keeps 0x61");
        do_read(3'd0, 8'h62, rd);  check(rd, 8'h3C, 8, "soft keeps 0x62");

        // R8: coincident write to 0x63 is discarded
        do_write(3'd0, 8'h63, 8'hFF);
        @(negedge clk);
        soft_rst = 1'b1; cfg_func = 3'd0; cfg_addr = 8'h63; cfg_wdata = 8'h00; cfg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        soft_rst = 1'b0; cfg_we = 1'b0;
        do_read(3'd0, 8'h63, rd);  check(rd, 8'hCF, 8, "soft beats write 0x63");

        // R8: coincident write to another byte still lands
        @(negedge clk);
        soft_rst = 1'b1; cfg_func = 3'd0; cfg_addr = 8'h62; cfg_wdata = 8'h5E; cfg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        soft_rst = 1'b0; cfg_we = 1'b0;
        do_read(3'd0, 8'h62, rd);  check(rd, 8'h5E, 8, "write 0x62 during soft");

        // R1: hard reset restores shadow and written bytes
        hard_reset();
        do_read(3'd0, 8'h63, rd);  check(rd, 8'h00, 1, "0x63 after reset");
        do_read(3'd0, 8'h64, rd);  check(rd, 8'hAB, 1, "0x64 after reset");
        do_read(3'd0, 8'h04, rd);  check(rd, 8'h07, 1, "0x04 after reset");
        #1;
        check(shadow_lo, 8'h00, 1, "shadow_lo after reset");

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule